// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns one decoded memory-operand request into the byte address that the load/store path will use. For each request it takes a mode code, the contents of a base register and an index register, a sign-extended literal taken from the instruction, an index scale code, an access size code and the current program counter. One cycle later it presents the effective address. In the same cycle it presents the value the base register should hold afterwards, together with an enable that tells the register file whether to write it.

Ten modes share one datapath. Each mode routes up to three operands into a single three-input adder. A separate stepping unit computes the base register side effect. Post-increment hands out the old base and then advances it by the access size. Pre-decrement lowers the base first and hands out the lowered value. The upper-literal mode keeps the high bits of a base register that was loaded with an upper constant, and adds a sign-extended 12-bit low offset taken from the literal. All arithmetic wraps modulo 2^32. The register file, the memory access and any indirection through memory are left to the surrounding pipeline.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (absolute): the effective address equals the literal input unchanged.
- R2: Mode code 1 (indexed absolute): the effective address is literal + index, modulo 2^32.
- R3: Mode code 2 gives base + index, and mode code 3 gives base + index + literal, both modulo 2^32.
- R4: Mode code 4 (scaled): the effective address is base + (index shifted left by the scale code). Scale codes 0, 1, 2 and 3 shift by 0, 1, 2 and 3 bits, so code 3 suits 8-byte elements.
- R5: Mode code 5 (register indirect): the effective address equals the base input.
- R6: Mode code 6 (post-increment): the effective address is the old base. The writeback value is base + 2^size, where size codes 0..3 mean 1, 2, 4 and 8 bytes.
- R7: Mode code 7 (pre-decrement): the effective address and the writeback value are both base − 2^size.
- R8: Mode code 8 (PC-relative): the effective address is the program counter + literal.
- R9: Mode code 9 (upper literal): the effective address is {base[31:12], 12'b0} + sign-extended literal[11:0]. Base bits 11:0 and literal bits 31:12 have no effect.
- R10: The writeback enable is 1 only for a request in mode 6 or 7. For every other mode the writeback value equals the unchanged base. Reserved codes 10..15 give effective address 0.
- R11: out_valid is req_valid delayed by one clock, and the results of a request appear in that same cycle. In a cycle with no request, out_wb_en is 0 and out_ea and out_wb_data keep their previous values.
- R12: While rst is high, at the next clock edge all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_mode | input | 4 | Addressing mode code (0..9; 10..15 are reserved) |
| req_base | input | 32 | Base register contents |
| req_index | input | 32 | Index register contents |
| req_lit | input | 32 | Sign-extended literal or address field from the instruction |
| req_scale | input | 2 | Index shift amount, 0..3 |
| req_size | input | 2 | Access size code, 2^code bytes |
| req_pc | input | 32 | Program counter of the requesting instruction |
| out_valid | output | 1 | Results below belong to the previous cycle's request |
| out_ea | output | 32 | Effective address |
| out_wb_en | output | 1 | Write out_wb_data back to the base register |
| out_wb_data | output | 32 | New base register value |

## Verification
Every internal state of this block lives in the output register bank, so any wrong routing, step or decode shows up on the ports in the very next cycle. A stale enable or a held value that wrongly changes appears in the cycle after an idle slot. A wrong operand selection shows as an address mismatch for that mode alone. A wrong step size shows only for the auto-modifying modes, and only with the size codes it gets wrong. The stimulus therefore sweeps every mode with random operands and all scale and size codes. It adds the wrap-around cases: a post-increment near the top of the address space, a pre-decrement from zero, and an upper-literal with a negative low offset.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    localparam int unsigned MODE_W  = 4;
    localparam int unsigned SCALE_W = 2;
    localparam int unsigned SIZE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_ABS      = 4'd0,
        AM_IDX_ABS  = 4'd1,
        AM_BASE_IDX = 4'd2,
        AM_BIO      = 4'd3,
        AM_SCALED   = 4'd4,
        AM_IND      = 4'd5,
        AM_POSTINC  = 4'd6,
        AM_PREDEC   = 4'd7,
        AM_PCREL    = 4'd8,
        AM_UPPER    = 4'd9
    } am_mode_e;

    // Operand A of the adder.
    typedef enum logic [2:0] {
        SA_ZERO    = 3'd0,
        SA_BASE    = 3'd1,
        SA_PC      = 3'd2,
        SA_LIT     = 3'd3,
        SA_BASE_HI = 3'd4
    } srca_e;

    // Operand B of the adder.
    typedef enum logic [1:0] {
        SB_ZERO     = 2'd0,
        SB_INDEX    = 2'd1,
        SB_SCALED   = 2'd2,
        SB_NEG_STEP = 2'd3
    } srcb_e;

    // Operand C of the adder.
    typedef enum logic [1:0] {
        SC_ZERO    = 2'd0,
        SC_LIT     = 2'd1,
        SC_LIT_LOW = 2'd2
    } srcc_e;

    typedef struct packed {
        srca_e a;
        srcb_e b;
        srcc_e c;
        logic  wb;       // base register side effect
        logic  step_up;  // direction of the side effect
    } route_t;

    function automatic logic [3:0] size_bytes(input logic [SIZE_W-1:0] code);
        return 4'(1 << code);
    endfunction

    function automatic route_t decode_mode(input am_mode_e m);
        route_t r;
        r = '{a: SA_ZERO, b: SB_ZERO, c: SC_ZERO, wb: 1'b0, step_up: 1'b0};
        case (m)
            AM_ABS:      r.a = SA_LIT;
            AM_IDX_ABS:  begin r.a = SA_LIT;  r.b = SB_INDEX; end
            AM_BASE_IDX: begin r.a = SA_BASE; r.b = SB_INDEX; end
            AM_BIO:      begin r.a = SA_BASE; r.b = SB_INDEX; r.c = SC_LIT; end
            AM_SCALED:   begin r.a = SA_BASE; r.b = SB_SCALED; end
            AM_IND:      r.a = SA_BASE;
            AM_POSTINC:  begin r.a = SA_BASE; r.wb = 1'b1; r.step_up = 1'b1; end
            AM_PREDEC:   begin r.a = SA_BASE; r.b = SB_NEG_STEP; r.wb = 1'b1; end
            AM_PCREL:    begin r.a = SA_PC;   r.c = SC_LIT; end
            AM_UPPER:    begin r.a = SA_BASE_HI; r.c = SC_LIT_LOW; end
            default:     ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ea_gen_decode.sv
module ea_gen_decode
    import ea_gen_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output route_t            route_o
);
    always_comb begin
        route_o = decode_mode(am_mode_e'(mode_i));
    end
endmodule

// File: rtl/ea_gen_operands.sv
module ea_gen_operands
    import ea_gen_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LOW_W  = 12
) (
    input  route_t              route_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   index_i,
    input  logic [ADDR_W-1:0]   lit_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [SCALE_W-1:0]  scale_i,
    input  logic [SIZE_W-1:0]   size_i,
    output logic [ADDR_W-1:0]   opa_o,
    output logic [ADDR_W-1:0]   opb_o,
    output logic [ADDR_W-1:0]   opc_o
);
    localparam int unsigned HI_W = ADDR_W - LOW_W;

    logic [ADDR_W-1:0] base_hi;
    logic [ADDR_W-1:0] lit_low_sx;
    logic [ADDR_W-1:0] idx_scaled;
    logic [ADDR_W-1:0] step_mag;

    always_comb begin
        base_hi    = {base_i[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
        lit_low_sx = {{HI_W{lit_i[LOW_W-1]}}, lit_i[LOW_W-1:0]};
        idx_scaled = index_i << scale_i;
        step_mag   = ADDR_W'(size_bytes(size_i));
    end

    always_comb begin
        case (route_i.a)
            SA_BASE:    opa_o = base_i;
            SA_PC:      opa_o = pc_i;
            SA_LIT:     opa_o = lit_i;
            SA_BASE_HI: opa_o = base_hi;
            default:    opa_o = '0;
        endcase
    end

    always_comb begin
        case (route_i.b)
            SB_INDEX:    opb_o = index_i;
            SB_SCALED:   opb_o = idx_scaled;
            SB_NEG_STEP: opb_o = ~step_mag + ADDR_W'(1);
            default:     opb_o = '0;
        endcase
    end

    always_comb begin
        case (route_i.c)
            SC_LIT:     opc_o = lit_i;
            SC_LIT_LOW: opc_o = lit_low_sx;
            default:    opc_o = '0;
        endcase
    end
endmodule

// File: rtl/ea_gen_step.sv
module ea_gen_step
    import ea_gen_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              up_i,
    output logic [ADDR_W-1:0] next_o
);
    logic [ADDR_W-1:0] mag;

    always_comb begin
        mag    = ADDR_W'(size_bytes(size_i));
        next_o = up_i ? (base_i + mag) : (base_i - mag);
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LOW_W  = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [MODE_W-1:0]   req_mode,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [ADDR_W-1:0]   req_index,
    input  logic [ADDR_W-1:0]   req_lit,
    input  logic [SCALE_W-1:0]  req_scale,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [ADDR_W-1:0]   req_pc,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   out_ea,
    output logic                out_wb_en,
    output logic [ADDR_W-1:0]   out_wb_data
);
    route_t            route;
    logic [ADDR_W-1:0] opa, opb, opc;
    logic [ADDR_W-1:0] ea_sum;
    logic [ADDR_W-1:0] step_val;

    ea_gen_decode u_decode (
        .mode_i  (req_mode),
        .route_o (route)
    );

    ea_gen_operands #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_operands (
        .route_i (route),
        .base_i  (req_base),
        .index_i (req_index),
        .lit_i   (req_lit),
        .pc_i    (req_pc),
        .scale_i (req_scale),
        .size_i  (req_size),
        .opa_o   (opa),
        .opb_o   (opb),
        .opc_o   (opc)
    );

    ea_gen_step #(.ADDR_W(ADDR_W)) u_step (
        .base_i (req_base),
        .size_i (req_size),
        .up_i   (route.step_up),
        .next_o (step_val)
    );

    always_comb begin
        ea_sum = opa + opb + opc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_ea      <= '0;
            out_wb_en   <= 1'b0;
            out_wb_data <= '0;
        end else begin
            out_valid <= req_valid;
            out_wb_en <= req_valid & route.wb;
            if (req_valid) begin
                out_ea      <= ea_sum;
                out_wb_data <= route.wb ? step_val : req_base;
            end
        end
    end

    // R11: results follow the request by exactly one cycle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    a_r11_hold_ea: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> ($stable(out_ea) && $stable(out_wb_data)));

    // R6: post-increment hands out the old base
    a_r6_post_old_base: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(req_mode) == MODE_W'(AM_POSTINC)) |-> (out_ea == $past(req_base)));

    // R7: pre-decrement address equals the new base
    a_r7_pre_match: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(req_mode) == MODE_W'(AM_PREDEC)) |-> (out_ea == out_wb_data));

    // R10: writeback only for the two auto-modifying modes
    a_r10_wb_modes: assert property (@(posedge clk) disable iff (rst)
        out_wb_en |-> (out_valid && ($past(req_mode) == MODE_W'(AM_POSTINC) ||
                                     $past(req_mode) == MODE_W'(AM_PREDEC))));
    a_r10_base_kept: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_wb_en) |-> (out_wb_data == $past(req_base)));
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [3:0]  req_mode;
    logic [31:0] req_base, req_index, req_lit, req_pc;
    logic [1:0]  req_scale, req_size;
    logic        out_valid, out_wb_en;
    logic [31:0] out_ea, out_wb_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    ea_gen u_ea_gen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_base(req_base), .req_index(req_index), .req_lit(req_lit),
        .req_scale(req_scale), .req_size(req_size), .req_pc(req_pc),
        .out_valid(out_valid), .out_ea(out_ea), .out_wb_en(out_wb_en),
        .out_wb_data(out_wb_data)
    );

    function automatic logic [31:0] ref_ea(input logic [3:0] m, input logic [31:0] b,
        input logic [31:0] i, input logic [31:0] l, input logic [31:0] p,
        input logic [1:0] sc, input logic [1:0] sz);
        logic [31:0] st;
        st = 32'd1 << sz;
        case (m)
            4'd0: return l;
            4'd1: return l + i;
            4'd2: return b + i;
            4'd3: return b + i + l;
            4'd4: return b + (i << sc);
            4'd5: return b;
            4'd6: return b;
            4'd7: return b - st;
            4'd8: return p + l;
            4'd9: return {b[31:12], 12'h000} + {{20{l[11]}}, l[11:0]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] ref_wb(input logic [3:0] m, input logic [31:0] b,
        input logic [1:0] sz);
        logic [31:0] st;
        st = 32'd1 << sz;
        if (m == 4'd6) return b + st;
        if (m == 4'd7) return b - st;
        return b;
    endfunction

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] m, input logic [31:0] b, input logic [31:0] i,
                         input logic [31:0] l, input logic [31:0] p,
                         input logic [1:0] sc, input logic [1:0] sz);
        logic [31:0] e_ea, e_wb;
        logic        e_en;
        req_valid = 1'b1; req_mode = m; req_base = b; req_index = i;
        req_lit = l; req_pc = p; req_scale = sc; req_size = sz;
        e_ea = ref_ea(m, b, i, l, p, sc, sz);
        e_wb = ref_wb(m, b, sz);
        e_en = (m == 4'd6) || (m == 4'd7);
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid == 1'b1, "R11", "out_valid", 32'(out_valid), 32'd1);
        chk(out_ea == e_ea, tag_of(m), "out_ea", out_ea, e_ea);
        chk(out_wb_en == e_en, "R10", "out_wb_en", 32'(out_wb_en), 32'(e_en));
        chk(out_wb_data == e_wb, e_en ? tag_of(m) : "R10", "out_wb_data", out_wb_data, e_wb);
    endtask

    task automatic idle_check();
        logic [31:0] held_ea, held_wb;
        held_ea = out_ea;
        held_wb = out_wb_data;
        req_valid = 1'b0;
        req_base  = $urandom;
        req_mode  = 4'd6;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "idle out_valid", 32'(out_valid), 32'd0);
        chk(out_wb_en == 1'b0, "R11", "idle out_wb_en", 32'(out_wb_en), 32'd0);
        chk(out_ea == held_ea, "R11", "idle out_ea held", out_ea, held_ea);
        chk(out_wb_data == held_wb, "R11", "idle out_wb_data held", out_wb_data, held_wb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        rst = 1'b1; req_valid = 1'b0; req_mode = '0; req_base = '0; req_index = '0;
        req_lit = '0; req_pc = '0; req_scale = '0; req_size = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(out_valid == 1'b0, "R12", "reset out_valid", 32'(out_valid), 32'd0);
        chk(out_ea == 32'd0, "R12", "reset out_ea", out_ea, 32'd0);
        chk(out_wb_en == 1'b0, "R12", "reset out_wb_en", 32'(out_wb_en), 32'd0);
        chk(out_wb_data == 32'd0, "R12", "reset out_wb_data", out_wb_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corners
        issue(4'd0, 32'h1111_1111, 32'h2222_2222, 32'hDEAD_BEEF, 32'h0, 2'd0, 2'd2); // R1
        issue(4'd1, 32'h0, 32'h0000_0010, 32'hFFFF_FFF8, 32'h0, 2'd0, 2'd0);       // R2 wrap
        issue(4'd3, 32'h0000_1000, 32'h0000_0040, 32'h0000_0008, 32'h0, 2'd0, 2'd0); // R3
        issue(4'd4, 32'h0000_2000, 32'h0000_0005, 32'h0, 32'h0, 2'd3, 2'd3);       // R4 8-byte
        issue(4'd5, 32'hCAFE_0000, 32'h1, 32'h1, 32'h1, 2'd1, 2'd1);              // R5
        issue(4'd6, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 2'd0, 2'd3);              // R6 wrap
        issue(4'd7, 32'h0000_0000, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0);              // R7 from 0
        issue(4'd7, 32'h0000_0100, 32'h0, 32'h0, 32'h0, 2'd0, 2'd2);              // R7 size 4
        issue(4'd8, 32'h0, 32'h0, 32'hFFFF_FFF0, 32'h0000_4000, 2'd0, 2'd0);      // R8 negative
        issue(4'd9, 32'h1234_5FFF, 32'h0, 32'h7777_7800, 32'h0, 2'd0, 2'd0);      // R9 neg low
        issue(4'd9, 32'h8000_0ABC, 32'h0, 32'h0000_07FF, 32'h0, 2'd0, 2'd0);      // R9 pos low
        issue(4'd12, 32'h5555_5555, 32'h1, 32'h2, 32'h3, 2'd1, 2'd1);             // R10 reserved
        idle_check();                                                              // R11

        // Constrained random sweep over all modes and codes
        for (int k = 0; k < 600; k++) begin
            logic [3:0] m;
            m = (($urandom % 8) == 0) ? 4'($urandom % 16) : 4'($urandom % 10);
            issue(m, $urandom, $urandom, $urandom, $urandom,
                  2'($urandom % 4), 2'($urandom % 4));
            if ((k % 9) == 0) idle_check();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule